// File: doc/BRIEF.md
# Strap-Selected Configuration Unlock Sequencer

This block guards the configuration space of an I/O controller. Normally that space is closed. To open it, software writes a key byte to an enable address. The key, the enable address and the number of consecutive key writes needed all come from two hardware strap inputs. While the space is open, software selects a register through an index port and reads or writes it through a data port. Both ports move with the enable address. Writing the exit byte to the enable address closes the space again.

The register file holds four kinds of content:
- a mode register, whose bits 3:2 select the parallel port mode;
- a chip register, whose bits 7:4 are writable and whose bits 3:0 hold a fixed chip ID;
- a read-only copy of the two straps;
- a base register, which stores the parallel port address divided by four.

The base and mode settings leave the block as decoded outputs for the function blocks they configure.

The straps are treated as static. They may only change while reset is held.

Top module: `cfg_key_unlock`

## Requirements
- R1: After reset the space is closed:
  - `cfgOpen` is 0.
  - `portBaseAddr` is 0x378 (base register 0xDE).
  - `portMode` is 0 (not parallel).
- R2: With strapHiPort=0, a single write to 0x250 opens the space. The required key is 0x88 when strapKeyLsb=0 and 0x89 when strapKeyLsb=1. `cfgOpen` is 1 from the clock edge that takes the write.
- R3: With strapHiPort=1, two consecutive writes to 0x3F0 open the space. The required key is 0x86 when strapKeyLsb=0 and 0x87 when strapKeyLsb=1. After only the first key write the space stays closed.
- R4: While the space is closed, any write that is not the correct key to the enable address discards the key progress. This includes a wrong value at the enable address and any write to another address. A full key sequence is then needed again.
- R5: While the space is closed:
  - reads of the index port and the data port return 0xFF;
  - writes to either port change no register and do not change the index.
- R6: The index and data ports depend on strapHiPort:
  - with strapHiPort=0 they are 0x251 and 0x252;
  - with strapHiPort=1 they are 0x3F0 and 0x3F1.
  While the space is open, a read of the index port returns the current index. A read of any other address returns 0xFF.
- R7: Register 0x0C is read-only. It reads strapHiPort in bit 1, strapKeyLsb in bit 0, and zeros in bits 7:2.
- R8: Register 0x23 is readable and writable and holds the base address divided by four. `portBaseAddr` equals its value times four and changes only when that register is written.
- R9: In register 0x09, bits 7:4 are writable and bits 3:0 always read the chip ID 0xA.
- R10: `portMode` is decoded from register 0x09 bit 7 and register 0x00 bits 3:2:
  - if bit 7 is 0, the mode is 0 (not parallel);
  - otherwise bits 3:2 give the mode: 0 not parallel, 1 EPP+SPP, 2 ECP, 3 ECP+EPP.
- R11: While the space is open, writing 0xAA to the enable address closes it from that clock edge and clears the index to 0. With strapHiPort=1 this write takes precedence over an index write. With strapHiPort=0, any other value written to 0x250 has no effect.
- R12: While the space is open, reading a register index other than 0x00, 0x09, 0x0C or 0x23 returns 0x00, and writes to such an index change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strapHiPort | input | 1 | Strap: 1 selects the 0x3F0 map with a two-write key |
| strapKeyLsb | input | 1 | Strap: selects between the two keys of the map |
| ioWr | input | 1 | Write strobe, one cycle per write |
| ioRd | input | 1 | Read strobe |
| ioAddr | input | 12 | I/O address |
| ioWrData | input | 8 | Write data |
| ioRdData | output | 8 | Read data, combinational from address and state |
| cfgOpen | output | 1 | Configuration space is open |
| portBaseAddr | output | 10 | Parallel port base address (base register times four) |
| portMode | output | 2 | Decoded parallel port mode |

## Verification
Wrong key progress shows at `cfgOpen` only on the clock edge of the next key write. It appears as a space that opens one write early, or that needs an extra write.

A lost open state, or an index that is not cleared on exit, shows at the next index or data read. That read returns 0xFF or a stale index instead of the expected value. Register corruption shows on `portBaseAddr` and `portMode` one edge after the faulty data write.

The bench therefore compares `cfgOpen` and the decoded outputs after every write, and compares read data on every read, against a model of the key and register state.

// File: rtl/cfgkey_pkg.sv
package cfgkey_pkg;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_INDEX = 2'd1,
    RD_DATA  = 2'd2
  } rdSel_e;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_EPP_SPP = 2'd1,
    MODE_ECP     = 2'd2,
    MODE_ECP_EPP = 2'd3
  } portMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   idxWr;
    logic   dataWr;
    logic   idxClr;
    logic   isOpen;
    rdSel_e rdSel;
  } cfgStrobe_t;

endpackage

// File: rtl/cfgkey_ctrl.sv
module cfgkey_ctrl
  import cfgkey_pkg::*;
#(
  parameter int              ADDR_W     = 12,
  parameter int              DATA_W     = 8,
  parameter logic [11:0]     EN_ADDR_LO = 12'h250,
  parameter logic [11:0]     EN_ADDR_HI = 12'h3F0,
  parameter logic [7:0]      KEY_LO0    = 8'h88,
  parameter logic [7:0]      KEY_LO1    = 8'h89,
  parameter logic [7:0]      KEY_HI0    = 8'h86,
  parameter logic [7:0]      KEY_HI1    = 8'h87,
  parameter int              REPS_LO    = 1,
  parameter int              REPS_HI    = 2,
  parameter logic [7:0]      EXIT_KEY   = 8'hAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strapHiPort,
  input  logic              strapKeyLsb,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioWrData,
  output cfgStrobe_t        strb
);

  localparam int REPS_MAX = (REPS_HI > REPS_LO) ? REPS_HI : REPS_LO;
  localparam int CNT_W    = $clog2(REPS_MAX + 1);

  localparam logic [ADDR_W-1:0] EN_LO   = ADDR_W'(EN_ADDR_LO);
  localparam logic [ADDR_W-1:0] EN_HI   = ADDR_W'(EN_ADDR_HI);
  localparam logic [ADDR_W-1:0] IDX_LO  = EN_LO + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] DAT_LO  = EN_LO + ADDR_W'(2);
  localparam logic [ADDR_W-1:0] IDX_HI  = EN_HI;
  localparam logic [ADDR_W-1:0] DAT_HI  = EN_HI + ADDR_W'(1);

  localparam logic [DATA_W-1:0] KEY_TAB [4] = '{
    DATA_W'(KEY_LO0), DATA_W'(KEY_LO1), DATA_W'(KEY_HI0), DATA_W'(KEY_HI1)
  };

  logic [ADDR_W-1:0] enAddr;
  logic [ADDR_W-1:0] idxAddr;
  logic [ADDR_W-1:0] dataAddr;
  logic [DATA_W-1:0] keyVal;
  logic [CNT_W-1:0]  needReps;

  logic              openQ;
  logic [CNT_W-1:0]  keyCnt;
  logic [CNT_W-1:0]  keyCntNext;

  logic              hitEn;
  logic              keyHit;
  logic              exitHit;

  // Strap-driven address map and key choice
  always_comb begin
    enAddr   = strapHiPort ? EN_HI  : EN_LO;
    idxAddr  = strapHiPort ? IDX_HI : IDX_LO;
    dataAddr = strapHiPort ? DAT_HI : DAT_LO;
    keyVal   = KEY_TAB[{strapHiPort, strapKeyLsb}];
    needReps = strapHiPort ? CNT_W'(REPS_HI) : CNT_W'(REPS_LO);
  end

  assign hitEn      = ioWr && (ioAddr == enAddr);
  assign keyHit     = hitEn && (ioWrData == keyVal);
  assign exitHit    = hitEn && (ioWrData == DATA_W'(EXIT_KEY));
  assign keyCntNext = keyCnt + CNT_W'(1);

  // Lock state and key progress
  always_ff @(posedge clk) begin
    if (rst) begin
      openQ  <= 1'b0;
      keyCnt <= '0;
    end else if (openQ) begin
      keyCnt <= '0;
      if (exitHit) begin
        openQ <= 1'b0;
      end
    end else if (ioWr) begin
      if (keyHit) begin
        if (keyCntNext >= needReps) begin
          openQ  <= 1'b1;
          keyCnt <= '0;
        end else begin
          keyCnt <= keyCntNext;
        end
      end else begin
        keyCnt <= '0;
      end
    end
  end

  // Strobes toward the register datapath
  always_comb begin
    strb        = '0;
    strb.isOpen = openQ;
    strb.idxClr = openQ && exitHit;
    strb.idxWr  = openQ && ioWr && (ioAddr == idxAddr) && !exitHit;
    strb.dataWr = openQ && ioWr && (ioAddr == dataAddr);
    if (openQ && ioRd) begin
      if (ioAddr == idxAddr) begin
        strb.rdSel = RD_INDEX;
      end else if (ioAddr == dataAddr) begin
        strb.rdSel = RD_DATA;
      end else begin
        strb.rdSel = RD_NONE;
      end
    end else begin
      strb.rdSel = RD_NONE;
    end
  end

  // R2 / R3: the space only opens on an edge that took a correct key write
  a_r3_open_needs_key : assert property (@(posedge clk) disable iff (rst)
    $rose(openQ) |-> $past(ioWr && (ioAddr == enAddr) && (ioWrData == keyVal)));

  // R4: while closed, a write anywhere other than the enable address discards progress
  a_r4_abort_clears : assert property (@(posedge clk) disable iff (rst)
    (!openQ && ioWr && (ioAddr != enAddr)) |=> (keyCnt == '0) && !openQ);

  // R11: exit byte at the enable address closes the space
  a_r11_exit_closes : assert property (@(posedge clk) disable iff (rst)
    (openQ && ioWr && (ioAddr == enAddr) && (ioWrData == DATA_W'(EXIT_KEY))) |=> !openQ);

  // R4: key progress never reaches the repetition count while still closed
  a_r4_cnt_bounded : assert property (@(posedge clk) disable iff (rst)
    !openQ |-> (keyCnt < needReps));

endmodule

// File: rtl/cfgkey_regs.sv
module cfgkey_regs
  import cfgkey_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  IDX_MODE  = 8'h00,
  parameter logic [7:0]  IDX_CHIP  = 8'h09,
  parameter logic [7:0]  IDX_STRAP = 8'h0C,
  parameter logic [7:0]  IDX_BASE  = 8'h23,
  parameter logic [3:0]  CHIP_ID   = 4'hA,
  parameter logic [7:0]  BASE_RST  = 8'hDE
) (
  input  logic              clk,
  input  logic              rst,
  input  cfgStrobe_t        strb,
  input  logic              strapHiPort,
  input  logic              strapKeyLsb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W+1:0] portBaseAddr,
  output portMode_e         portMode
);

  localparam int HI_W = DATA_W - 4;

  logic [DATA_W-1:0] idxQ;
  logic [DATA_W-1:0] modeRegQ;
  logic [HI_W-1:0]   chipHiQ;
  logic [DATA_W-1:0] baseQ;
  logic [DATA_W-1:0] regValue;
  logic              portEnable;
  logic [1:0]        modeBits;

  // Index register
  always_ff @(posedge clk) begin
    if (rst) begin
      idxQ <= '0;
    end else if (strb.idxClr) begin
      idxQ <= '0;
    end else if (strb.idxWr) begin
      idxQ <= wrData;
    end
  end

  // Writable configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      modeRegQ <= '0;
      chipHiQ  <= '0;
      baseQ    <= DATA_W'(BASE_RST);
    end else if (strb.dataWr) begin
      case (idxQ)
        DATA_W'(IDX_MODE): modeRegQ <= wrData;
        DATA_W'(IDX_CHIP): chipHiQ  <= wrData[DATA_W-1:4];
        DATA_W'(IDX_BASE): baseQ    <= wrData;
        default: ;
      endcase
    end
  end

  // Register read selection
  always_comb begin
    case (idxQ)
      DATA_W'(IDX_MODE):  regValue = modeRegQ;
      DATA_W'(IDX_CHIP):  regValue = {chipHiQ, CHIP_ID};
      DATA_W'(IDX_STRAP): regValue = {{(DATA_W-2){1'b0}}, strapHiPort, strapKeyLsb};
      DATA_W'(IDX_BASE):  regValue = baseQ;
      default:            regValue = '0;
    endcase
  end

  always_comb begin
    case (strb.rdSel)
      RD_INDEX: rdData = idxQ;
      RD_DATA:  rdData = regValue;
      default:  rdData = '1;
    endcase
  end

  // Decoded outputs
  assign portBaseAddr = {baseQ, 2'b00};
  assign portEnable   = chipHiQ[HI_W-1];
  assign modeBits     = modeRegQ[3:2];

  always_comb begin
    if (!portEnable) begin
      portMode = MODE_OFF;
    end else begin
      portMode = portMode_e'(modeBits);
    end
  end

  // R5: index register cannot move while the space is closed
  a_r5_locked_idx_hold : assert property (@(posedge clk) disable iff (rst)
    !strb.isOpen |=> $stable(idxQ));

  // R5: closed space never returns register content
  a_r5_locked_reads_ff : assert property (@(posedge clk) disable iff (rst)
    !strb.isOpen |-> (rdData == '1));

  // R9: chip ID nibble always visible on a data read of the chip register
  a_r9_chip_id : assert property (@(posedge clk) disable iff (rst)
    ((strb.rdSel == RD_DATA) && (idxQ == DATA_W'(IDX_CHIP))) |-> (rdData[3:0] == CHIP_ID));

  // R8: base output holds unless the base register is written
  a_r8_base_hold : assert property (@(posedge clk) disable iff (rst)
    !(strb.dataWr && (idxQ == DATA_W'(IDX_BASE))) |=> $stable(portBaseAddr));

  // R11: exit clears the index
  a_r11_idx_cleared : assert property (@(posedge clk) disable iff (rst)
    strb.idxClr |=> (idxQ == '0));

endmodule

// File: rtl/cfg_key_unlock.sv
module cfg_key_unlock
  import cfgkey_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strapHiPort,
  input  logic              strapKeyLsb,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioWrData,
  output logic [DATA_W-1:0] ioRdData,
  output logic              cfgOpen,
  output logic [DATA_W+1:0] portBaseAddr,
  output logic [1:0]        portMode
);

  cfgStrobe_t strb;
  portMode_e  modeSel;

  cfgkey_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .strapHiPort (strapHiPort),
    .strapKeyLsb (strapKeyLsb),
    .ioWr        (ioWr),
    .ioRd        (ioRd),
    .ioAddr      (ioAddr),
    .ioWrData    (ioWrData),
    .strb        (strb)
  );

  cfgkey_regs #(
    .DATA_W (DATA_W)
  ) u_regs (
    .clk          (clk),
    .rst          (rst),
    .strb         (strb),
    .strapHiPort  (strapHiPort),
    .strapKeyLsb  (strapKeyLsb),
    .wrData       (ioWrData),
    .rdData       (ioRdData),
    .portBaseAddr (portBaseAddr),
    .portMode     (modeSel)
  );

  assign cfgOpen  = strb.isOpen;
  assign portMode = modeSel;

endmodule

// File: tb/test_cfg_key_unlock.sv
`timescale 1ns/1ps
module test_cfg_key_unlock;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strapHiPort = 1'b0;
  logic        strapKeyLsb = 1'b1;
  logic        ioWr = 1'b0;
  logic        ioRd = 1'b0;
  logic [11:0] ioAddr = '0;
  logic [7:0]  ioWrData = '0;
  logic [7:0]  ioRdData;
  logic        cfgOpen;
  logic [9:0]  portBaseAddr;
  logic [1:0]  portMode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model state
  bit       mOpen;
  int       mCnt;
  bit [7:0] mIdx, mReg0, mBase;
  bit [3:0] mChipHi;

  always #4 clk = ~clk;

  cfg_key_unlock i_cfg_key_unlock (
    .clk(clk), .rst(rst), .strapHiPort(strapHiPort), .strapKeyLsb(strapKeyLsb),
    .ioWr(ioWr), .ioRd(ioRd), .ioAddr(ioAddr), .ioWrData(ioWrData),
    .ioRdData(ioRdData), .cfgOpen(cfgOpen), .portBaseAddr(portBaseAddr),
    .portMode(portMode)
  );

  function automatic bit [11:0] enA();
    return strapHiPort ? 12'h3F0 : 12'h250;
  endfunction
  function automatic bit [11:0] idxA();
    return strapHiPort ? 12'h3F0 : 12'h251;
  endfunction
  function automatic bit [11:0] datA();
    return strapHiPort ? 12'h3F1 : 12'h252;
  endfunction
  function automatic bit [7:0] keyV();
    case ({strapHiPort, strapKeyLsb})
      2'b00: return 8'h88;
      2'b01: return 8'h89;
      2'b10: return 8'h86;
      default: return 8'h87;
    endcase
  endfunction
  function automatic int repsV();
    return strapHiPort ? 2 : 1;
  endfunction
  function automatic bit [7:0] regVal(bit [7:0] i);
    case (i)
      8'h00: return mReg0;
      8'h09: return {mChipHi, 4'hA};
      8'h0C: return {6'b0, strapHiPort, strapKeyLsb};
      8'h23: return mBase;
      default: return 8'h00;
    endcase
  endfunction
  function automatic bit [7:0] expRead(bit [11:0] a);
    if (!mOpen) return 8'hFF;
    if (a == idxA()) return mIdx;
    if (a == datA()) return regVal(mIdx);
    return 8'hFF;
  endfunction
  function automatic bit [1:0] expMode();
    return mChipHi[3] ? mReg0[3:2] : 2'd0;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic modelWrite(bit [11:0] a, bit [7:0] d);
    if (mOpen) begin
      if (a == enA() && d == 8'hAA) begin
        mOpen = 0; mIdx = 0; mCnt = 0;
      end else begin
        if (a == idxA()) mIdx = d;
        if (a == datA()) begin
          case (mIdx)
            8'h00: mReg0 = d;
            8'h09: mChipHi = d[7:4];
            8'h23: mBase = d;
            default: ;
          endcase
        end
      end
    end else begin
      if (a == enA() && d == keyV()) begin
        mCnt++;
        if (mCnt >= repsV()) begin mOpen = 1; mCnt = 0; end
      end else begin
        mCnt = 0;
      end
    end
  endtask

  task automatic doWrite(bit [11:0] a, bit [7:0] d, string tag);
    @(negedge clk);
    ioWr = 1'b1; ioAddr = a; ioWrData = d;
    @(negedge clk);
    ioWr = 1'b0;
    modelWrite(a, d);
    check(tag, cfgOpen, mOpen);
    check(tag, portBaseAddr, {mBase, 2'b00});
    check(tag, portMode, expMode());
  endtask

  task automatic doRead(bit [11:0] a, string tag);
    @(negedge clk);
    ioRd = 1'b1; ioAddr = a;
    #1;
    check(tag, ioRdData, expRead(a));
    ioRd = 1'b0;
  endtask

  task automatic doReset(bit hi, bit lsb);
    @(negedge clk);
    rst = 1'b1; strapHiPort = hi; strapKeyLsb = lsb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mOpen = 0; mCnt = 0; mIdx = 0; mReg0 = 0; mBase = 8'hDE; mChipHi = 0;
    check("R1 open", cfgOpen, 0);
    check("R1 base", portBaseAddr, 10'h378);
    check("R1 mode", portMode, 0);
  endtask

  task automatic unlock();
    for (int k = 0; k < repsV(); k++) doWrite(enA(), keyV(), strapHiPort ? "R3" : "R2");
  endtask

  task automatic directed(bit hi, bit lsb);
    doReset(hi, lsb);
    // R5: closed-space accesses
    doWrite(idxA(), 8'h23, "R5 locked idx wr");
    doWrite(datA(), 8'h11, "R5 locked data wr");
    doRead(idxA(), "R5 locked idx rd");
    doRead(datA(), "R5 locked data rd");
    // R4: aborted sequences
    doWrite(enA(), keyV(), "R4 partial");
    doWrite(12'h100, 8'h00, "R4 other addr");
    if (hi) begin
      doWrite(enA(), keyV(), "R4 restart");
      check("R4 still closed", cfgOpen, 0);
      doWrite(enA(), 8'h55, "R4 wrong key");
      doWrite(enA(), keyV(), "R3 first only");
      check("R3 one write closed", cfgOpen, 0);
      doWrite(enA(), keyV(), "R3 second");
    end else begin
      doWrite(enA(), 8'h55, "R4 wrong key");
      doWrite(enA(), keyV(), "R2 single");
    end
    check("R2/R3 open", cfgOpen, 1);
    doRead(idxA(), "R5 index untouched");
    doRead(12'h2F8, "R6 other addr");
    doWrite(idxA(), 8'h0C, "R6 idx wr");
    doRead(idxA(), "R6 idx rd");
    doRead(datA(), "R7 strap reg");
    doWrite(datA(), 8'hFF, "R7 ro write");
    doRead(datA(), "R7 strap reg after wr");
    doWrite(idxA(), 8'h09, "R9 sel");
    doWrite(datA(), 8'hF0, "R9 write");
    doRead(datA(), "R9 chip id");
    doWrite(idxA(), 8'h00, "R10 sel");
    doWrite(datA(), 8'h08, "R10 ecp");
    check("R10 mode ecp", portMode, 2);
    doWrite(datA(), 8'h0C, "R10 ecp epp");
    doWrite(idxA(), 8'h23, "R8 sel");
    doWrite(datA(), 8'h9E, "R8 base");
    check("R8 base addr", portBaseAddr, 10'h278);
    doRead(datA(), "R8 base rd");
    doWrite(idxA(), 8'h15, "R12 sel");
    doWrite(datA(), 8'h77, "R12 wr");
    doRead(datA(), "R12 rd");
    if (!hi) doWrite(enA(), 8'h12, "R11 other value");
    check("R11 still open", cfgOpen, 1);
    doWrite(enA(), 8'hAA, "R11 exit");
    check("R11 closed", cfgOpen, 0);
    doRead(idxA(), "R11 locked rd");
    unlock();
    doRead(idxA(), "R11 index cleared");
  endtask

  initial begin
    bit [11:0] a;
    bit [7:0]  d;
    int        sel;
    void'($urandom(32'h5EED1));
    directed(1'b0, 1'b1);
    directed(1'b0, 1'b0);
    directed(1'b1, 1'b0);
    directed(1'b1, 1'b1);
    for (int blk = 0; blk < 8; blk++) begin
      doReset(1'($urandom), 1'($urandom));
      for (int n = 0; n < 400; n++) begin
        sel = $urandom_range(0, 9);
        case (sel)
          0, 1, 2: a = enA();
          3, 4:    a = idxA();
          5, 6:    a = datA();
          default: a = 12'($urandom_range(12'h200, 12'h3FF));
        endcase
        case ($urandom_range(0, 5))
          0, 1: d = keyV();
          2:    d = (n % 7 == 0) ? 8'hAA : 8'h23;
          3:    d = (($urandom_range(0, 1)) != 0) ? 8'h09 : 8'h00;
          4:    d = 8'h0C;
          default: d = 8'($urandom);
        endcase
        if ($urandom_range(0, 3) == 0) doRead(a, "R6 random read");
        else doWrite(a, d, "R4 random write");
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule